// File: doc/BRIEF.md
# DMA Channel Error Status Aggregator

This block keeps one sticky error flag for each of the 16 channels of a DMA engine. The transfer engine marks a channel as faulty with a one-cycle pulse on that channel's error line, and the flag stays set until software clears it.

Software can clear a flag in two ways. It can write a bitmap to the error status word, where each 1 clears the matching channel. It can also write a channel index to a separate clear-command address, and that command can also clear every channel at once.

A per-channel interrupt enable masks the flags, and the masked flags are OR-reduced into one registered group interrupt. A second output gives the unmasked OR of all flags, so software that polls the block sees pending errors whatever the enables are. The block has no effect on channel completion reporting, which lives elsewhere.

Top module: `dma_err_status`

## Requirements
- R1: The error status word is at byte offset 0x2C. Bit n holds the flag of channel n for n = 0..15, and bits 31:16 always read 0.
- R2: After synchronous reset, all error flags, all enable bits and `err_irq` are 0.
- R3: A 1 on `err_set[n]` sampled at a rising clock edge sets flag n from that edge on.
- R4: A write to offset 0x2C clears every flag whose data bit is 1 and leaves the flags whose data bit is 0 unchanged.
- R5: A write to the clear-command offset 0x30 with bit 6 = 0 clears only the flag of the channel given by data bits [3:0].
- R6: A write to offset 0x30 with bit 6 = 1 clears all 16 flags, whatever bits [3:0] hold.
- R7: When a set pulse and any clear for the same channel fall in the same cycle, the flag ends up set.
- R8: The interrupt enable word at offset 0x28 is read/write in bits 15:0, where bit n enables channel n. Its bits 31:16 read 0.
- R9: `err_irq` is registered. After each clock edge it equals the OR over n of (flag n AND enable n) as they stood before that edge.
- R10: `err_any` is the OR of all 16 flags, with no enable masking.
- R11: Offset 0x30 and every unmapped offset read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| err_set | input | 16 | Per-channel error pulse from the transfer engine |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | 8 | Byte offset of the register access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| err_irq | output | 1 | Registered group error interrupt |
| err_any | output | 1 | Unmasked OR of all error flags |

## Verification
The assertions check on every cycle that:
- no flag rises without its set pulse;
- a pulse always leaves its flag set, even when a clear hits the same cycle;
- a bitmap write clears the selected bits;
- the interrupt follows the masked flags with one cycle of delay;
- the unused upper read bits stay 0.

Only the bench's scenarios can show how the two clear paths interact with the index and clear-all encodings, that the enable word reads back, and that the summary output still rises while every enable is off. Long random runs, checked against a reference model, cover mixes of sets, clears and enable changes that directed cases do not reach.

// File: rtl/dma_err_pkg.sv
package dma_err_pkg;

    // Register byte offsets
    localparam int unsigned OFS_ENABLE  = 32'h28;
    localparam int unsigned OFS_ERRMAP  = 32'h2C;
    localparam int unsigned OFS_CLRCMD  = 32'h30;

    // Clear command field: index in low bits, clear-all flag at this bit
    localparam int unsigned CLR_ALL_BIT = 6;

    typedef enum logic [1:0] {
        SEL_NONE   = 2'd0,
        SEL_ENABLE = 2'd1,
        SEL_ERRMAP = 2'd2,
        SEL_CLRCMD = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic wr_enable;
        logic wr_errmap;
        logic wr_clrcmd;
    } wr_strobe_t;

    function automatic reg_sel_e decode_ofs(input logic [7:0] ofs);
        reg_sel_e s;
        case (ofs)
            8'(OFS_ENABLE): s = SEL_ENABLE;
            8'(OFS_ERRMAP): s = SEL_ERRMAP;
            8'(OFS_CLRCMD): s = SEL_CLRCMD;
            default:        s = SEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/dma_err_regif.sv
module dma_err_regif
    import dma_err_pkg::*;
#(
    parameter int NCH = 16,
    parameter int AW  = 8,
    parameter int DW  = 32
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           bus_wr,
    input  logic [AW-1:0]  bus_addr,
    input  logic [DW-1:0]  bus_wdata,
    input  logic [NCH-1:0] flags,
    output logic [NCH-1:0] enables,
    output logic [NCH-1:0] clr_mask,
    output logic [DW-1:0]  bus_rdata
);
    localparam int IDXW = (NCH > 1) ? $clog2(NCH) : 1;

    reg_sel_e       sel;
    wr_strobe_t     wst;
    logic [NCH-1:0] en_q;
    logic [NCH-1:0] map_clr;
    logic [NCH-1:0] cmd_clr;
    logic [IDXW-1:0] cmd_idx;

    always_comb begin
        sel = decode_ofs(8'(bus_addr));
        wst.wr_enable = bus_wr && (sel == SEL_ENABLE);
        wst.wr_errmap = bus_wr && (sel == SEL_ERRMAP);
        wst.wr_clrcmd = bus_wr && (sel == SEL_CLRCMD);
    end

    always_ff @(posedge clk) begin
        if (rst)
            en_q <= '0;
        else if (wst.wr_enable)
            en_q <= bus_wdata[NCH-1:0];
    end

    assign cmd_idx = bus_wdata[IDXW-1:0];

    always_comb begin
        map_clr = wst.wr_errmap ? bus_wdata[NCH-1:0] : '0;
        cmd_clr = '0;
        if (wst.wr_clrcmd) begin
            if (bus_wdata[CLR_ALL_BIT])
                cmd_clr = '1;
            else
                cmd_clr = NCH'(1) << cmd_idx;
        end
        clr_mask = map_clr | cmd_clr;
    end

    always_comb begin
        bus_rdata = '0;
        case (sel)
            SEL_ENABLE: bus_rdata[NCH-1:0] = en_q;
            SEL_ERRMAP: bus_rdata[NCH-1:0] = flags;
            default:    bus_rdata = '0;
        endcase
    end

    assign enables = en_q;

endmodule

// File: rtl/dma_err_flags.sv
module dma_err_flags #(
    parameter int NCH = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] set_i,
    input  logic [NCH-1:0] clr_i,
    output logic [NCH-1:0] flags_o
);
    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        always_ff @(posedge clk) begin
            if (rst)
                flags_o[ch] <= 1'b0;
            else if (set_i[ch])
                flags_o[ch] <= 1'b1;   // set has priority over clear
            else if (clr_i[ch])
                flags_o[ch] <= 1'b0;
        end
    end
endmodule

// File: rtl/dma_err_irq.sv
module dma_err_irq #(
    parameter int NCH = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] flags,
    input  logic [NCH-1:0] enables,
    output logic           irq_o,
    output logic           any_o
);
    logic [NCH-1:0] masked;

    assign masked = flags & enables;
    assign any_o  = |flags;

    always_ff @(posedge clk) begin
        if (rst)
            irq_o <= 1'b0;
        else
            irq_o <= |masked;
    end
endmodule

// File: rtl/dma_err_status.sv
module dma_err_status
    import dma_err_pkg::*;
#(
    parameter int NCH = 16,
    parameter int AW  = 8,
    parameter int DW  = 32
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] err_set,
    input  logic           bus_wr,
    input  logic [AW-1:0]  bus_addr,
    input  logic [DW-1:0]  bus_wdata,
    output logic [DW-1:0]  bus_rdata,
    output logic           err_irq,
    output logic           err_any
);
    logic [NCH-1:0] flags;
    logic [NCH-1:0] enables;
    logic [NCH-1:0] clr_mask;

    dma_err_regif #(.NCH(NCH), .AW(AW), .DW(DW)) u_regif (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .flags     (flags),
        .enables   (enables),
        .clr_mask  (clr_mask),
        .bus_rdata (bus_rdata)
    );

    dma_err_flags #(.NCH(NCH)) u_flags (
        .clk     (clk),
        .rst     (rst),
        .set_i   (err_set),
        .clr_i   (clr_mask),
        .flags_o (flags)
    );

    dma_err_irq #(.NCH(NCH)) u_irq (
        .clk     (clk),
        .rst     (rst),
        .flags   (flags),
        .enables (enables),
        .irq_o   (err_irq),
        .any_o   (err_any)
    );
endmodule

// File: rtl/dma_err_status_chk.sv
module dma_err_status_chk
    import dma_err_pkg::*;
#(
    parameter int NCH = 16,
    parameter int AW  = 8,
    parameter int DW  = 32
) (
    input logic           clk,
    input logic           rst,
    input logic [NCH-1:0] err_set,
    input logic           bus_wr,
    input logic [AW-1:0]  bus_addr,
    input logic [DW-1:0]  bus_wdata,
    input logic [DW-1:0]  bus_rdata,
    input logic           err_irq,
    input logic           err_any,
    input logic [NCH-1:0] flags,
    input logic [NCH-1:0] enables
);
    AST_RESET_CLEAN: assert property (@(posedge clk) $past(rst) |-> (flags == '0 && enables == '0 && !err_irq)); // R2
    AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (rst) ((flags & ~$past(flags) & ~$past(err_set)) == '0)); // R3
    AST_SET_STICKS: assert property (@(posedge clk) disable iff (rst) (|err_set) |=> ((flags & $past(err_set)) == $past(err_set))); // R7
    AST_MAP_CLEARS: assert property (@(posedge clk) disable iff (rst) (bus_wr && bus_addr == AW'(OFS_ERRMAP) && err_set == '0) |=> ((flags & $past(bus_wdata[NCH-1:0])) == '0)); // R4
    AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (rst) err_irq == $past(|(flags & enables))); // R9
    AST_IRQ_HAS_ERROR: assert property (@(posedge clk) disable iff (rst) err_irq |-> $past(err_any)); // R10
    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst) (bus_addr == AW'(OFS_ERRMAP)) |-> (bus_rdata[DW-1:NCH] == '0)); // R1
endmodule

bind dma_err_status dma_err_status_chk #(.NCH(NCH), .AW(AW), .DW(DW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .err_set   (err_set),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .err_irq   (err_irq),
    .err_any   (err_any),
    .flags     (flags),
    .enables   (enables)
);

// File: tb/test_dma_err_status.sv
`timescale 1ns/1ps
module test_dma_err_status;
    localparam logic [7:0] A_EN  = 8'h28;
    localparam logic [7:0] A_ERR = 8'h2C;
    localparam logic [7:0] A_CLR = 8'h30;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] err_set = '0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = A_ERR;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        err_irq, err_any;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    logic [15:0] m_flags = '0;
    logic [15:0] m_en = '0;
    logic        m_irq = 1'b0;

    always #2.5 clk = ~clk;

    dma_err_status i_dma_err_status (
        .clk(clk), .rst(rst), .err_set(err_set), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .err_irq(err_irq), .err_any(err_any)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] next_flags(input logic [15:0] f, input logic w,
            input logic [7:0] a, input logic [31:0] d, input logic [15:0] p);
        logic [15:0] r = f;
        if (w && a == A_ERR) r = r & ~d[15:0];
        if (w && a == A_CLR) begin
            if (d[6]) r = '0;
            else r[d[3:0]] = 1'b0;
        end
        return r | p;
    endfunction

    // Called just after a negedge; applies one cycle and checks outputs
    task automatic cyc(input string tag, input logic w, input logic [7:0] a,
                       input logic [31:0] d, input logic [15:0] p);
        bus_wr = w; bus_addr = a; bus_wdata = d; err_set = p;
        @(posedge clk);
        m_irq   = |(m_flags & m_en);
        m_flags = next_flags(m_flags, w, a, d, p);
        if (w && a == A_EN) m_en = d[15:0];
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = A_ERR; bus_wdata = '0; err_set = '0;
        #0.5;
        chk({tag, " R3/R1 flags"}, bus_rdata, {16'h0, m_flags});
        chk({tag, " R10 err_any"}, {31'h0, err_any}, {31'h0, |m_flags});
        chk({tag, " R9 err_irq"}, {31'h0, err_irq}, {31'h0, m_irq});
    endtask

    task automatic rdchk(input string tag, input logic [7:0] a, input logic [31:0] exp);
        bus_addr = a;
        #0.5;
        chk(tag, bus_rdata, exp);
        bus_addr = A_ERR;
        #0.5;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #0.5;
        // R2: reset state
        chk("R2 flags after reset", bus_rdata, 32'h0);
        chk("R2 irq after reset", {31'h0, err_irq}, 32'h0);
        rdchk("R2 R8 enable after reset", A_EN, 32'h0);

        cyc("R3 set ch3", 1'b0, A_ERR, 32'h0, 16'h0008);
        chk("R10 any without enable", {31'h0, err_any}, 32'h1);
        cyc("R8 enable write", 1'b1, A_EN, 32'hFFFF_0008, 16'h0);
        rdchk("R8 enable readback upper zero", A_EN, 32'h0000_0008);
        cyc("R9 irq rises", 1'b0, A_ERR, 32'h0, 16'h0);
        chk("R9 irq asserted", {31'h0, err_irq}, 32'h1);
        cyc("R3 set more", 1'b0, A_ERR, 32'h0, 16'hA021);
        cyc("R4 w1c partial", 1'b1, A_ERR, 32'hFFFF_2008, 16'h0);
        chk("R4 remaining flags", bus_rdata, 32'h0000_8021);
        cyc("R5 index clear ch5", 1'b1, A_CLR, 32'h0000_0005, 16'h0);
        chk("R5 only ch5 cleared", bus_rdata, 32'h0000_8001);
        cyc("R7 set wins cmd", 1'b1, A_CLR, 32'h0000_0000, 16'h0001);
        chk("R7 ch0 kept", bus_rdata, 32'h0000_8001);
        cyc("R7 set wins w1c", 1'b1, A_ERR, 32'h0000_8000, 16'h8000);
        chk("R7 ch15 kept", bus_rdata, 32'h0000_8001);
        rdchk("R11 clear cmd reads zero", A_CLR, 32'h0);
        rdchk("R11 unmapped reads zero", 8'h00, 32'h0);
        cyc("R6 clear all", 1'b1, A_CLR, 32'h0000_0043, 16'h0);
        chk("R6 all cleared", bus_rdata, 32'h0);
        cyc("R9 irq falls", 1'b0, A_ERR, 32'h0, 16'h0);
        chk("R9 irq low", {31'h0, err_irq}, 32'h0);

        for (int i = 0; i < 4000; i++) begin
            logic [2:0] k = 3'($urandom_range(0, 7));
            logic [7:0] a;
            logic w = ($urandom_range(0, 2) != 0);
            logic [31:0] d = $urandom;
            logic [15:0] p = ($urandom_range(0, 3) == 0) ? 16'($urandom) : 16'h0;
            case (k)
                3'd0, 3'd1: a = A_ERR;
                3'd2, 3'd3: a = A_CLR;
                3'd4:       a = A_EN;
                3'd5:       a = 8'h2C + 8'd4 * 8'($urandom_range(1, 3));
                default:    begin a = A_ERR; w = 1'b0; end
            endcase
            if (a == A_CLR && $urandom_range(0, 7) != 0) d[6] = 1'b0;
            cyc("R4/R5/R6/R7 random", w, a, d, p);
            if (i % 64 == 0) rdchk("R8 random enable", A_EN, {16'h0, m_en});
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule